// File: doc/BRIEF.md
# Serial-Bus EEPROM Target with Write Guard

This block is an I2C target that answers like a small byte-wide serial EEPROM. A fast system clock oversamples the bus clock and data lines. The block pulls the data line low through an output-enable and never drives it high. The array holds 256 bytes by default. Any power-of-two depth can be set by parameter, including a 128-byte variant. Three pins set the low bits of the target's bus address, so several copies can share one bus.

A bus master writes one to sixteen bytes into a 16-byte page and then ends the transfer with STOP. The page is then committed and the block stays busy for a programmable number of system clocks. It does not answer its address during that time, so the master can poll for completion. For reads, the master either continues from the internal address counter or first loads a new address through a dummy write and a repeated START. It then streams bytes for as long as it acknowledges them. A guard input, when high, refuses every data byte of a write and leaves the array intact.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, and while the bus is idle, `sdaOe` is 0 (the data line is released).
- R2: The block acknowledges a select byte only when bits 7:4 are 1010 and bits 3:1 equal `chipSel[2:0]`, with bit 0 = 1 for read and 0 for write. Any other select byte gets no acknowledge, and the block ignores the bus until the next START.
- R3: A write of select byte, word address and one data byte, ended by STOP, stores that byte. A later random read of that address returns it.
- R4: A write transaction stores up to 16 data bytes. The address advances only in its low 4 bits and rolls over inside the 16-byte page, while bits 7:4 stay fixed.
- R5: With `wrCtrl` high, the select byte and the word address are acknowledged, every data byte is not acknowledged, and the array is unchanged.
- R6: A STOP after at least one accepted data byte starts a busy period of `T_WRITE` system clocks, during which select bytes are not acknowledged. A STOP with no accepted data starts no busy period.
- R7: During a read, each byte sent advances the address by one. The address wraps from the top of the array to 0. The read continues while the master acknowledges and ends after a master NACK.
- R8: A read without a preceding address phase starts at the address that follows the last byte read or written.
- R9: A START or repeated START in any state restarts select-byte reception. Data taken in before a repeated START, with no STOP, is discarded.
- R10: `sdaOe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| chipSel | input | 3 | Address-select pins compared with select-byte bits 3:1 (tie low if unused) |
| wrCtrl | input | 1 | Write guard; high refuses data bytes (tie low if unused) |
| sdaOe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench sends select bytes that match, that differ only in the pin-set bits, and that differ in the fixed upper nibble. This tells the address decode apart from the busy lockout. Writes of a single byte, of a run that crosses a page edge, and of bytes with the guard raised separate in-page wraparound from refusal, and show that refusal leaves both the array and the busy timer untouched. Reads run as random, sequential across the top of the array, and current-address. A write cut short by a repeated START shows that an uncommitted page never reaches the array.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_ADDR,
    ST_ADDRACK,
    ST_WDATA,
    ST_WDACK,
    ST_RDATA,
    ST_RACK
  } ctrlState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic rxShift;    // shift rxBit into receive register
    logic rxBit;
    logic setAddr;    // load word address from receive register
    logic storeByte;  // place received byte into page buffer
    logic loadTx;     // fetch array byte at address, advance address
    logic shiftTx;    // next bit of transmit byte
    logic commit;     // write page buffer to array
    logic dropPage;   // discard page buffer
  } dpStrobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int T_WRITE     = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrCtrl,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       pagePending,
  output dpStrobe_t  stb,
  output logic       sdaOe
);

  localparam int TW_W = $clog2(T_WRITE + 1);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // write-cycle timer
  logic [TW_W-1:0] wCnt;
  logic busy;
  assign busy = (wCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wCnt <= '0;
    else if (stb.commit) wCnt <= TW_W'(T_WRITE);
    else if (busy)       wCnt <= wCnt - 1'b1;
  end

  // protocol state
  ctrlState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic       oe, oeN, rwBit, rwBitN, mAck, mAckN;
  logic       devHit;

  assign devHit = (rxByte[7:4] == 4'b1010) && (rxByte[3:1] == chipSel) && !busy;

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    oeN     = oe;
    rwBitN  = rwBit;
    mAckN   = mAck;
    stb     = '0;
    if (startDet) begin
      stateN       = ST_DEV;
      bitCntN      = '0;
      oeN          = 1'b0;
      stb.dropPage = 1'b1;
    end else if (stopDet) begin
      stateN     = ST_IDLE;
      oeN        = 1'b0;
      stb.commit = pagePending;
    end else begin
      unique case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.rxShift = 1'b1;
            stb.rxBit   = sdaS;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = '0;
            if (state == ST_DEV) begin
              if (devHit) begin
                oeN    = 1'b1;
                rwBitN = rxByte[0];
                stateN = ST_DEVACK;
              end else begin
                stateN = ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              oeN         = 1'b1;
              stb.setAddr = 1'b1;
              stateN      = ST_ADDRACK;
            end else begin
              stateN = ST_WDACK;
              if (!wrCtrl) begin
                oeN           = 1'b1;
                stb.storeByte = 1'b1;
              end
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            oeN = 1'b0;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stateN     = ST_RDATA;
            end else begin
              stateN = ST_ADDR;
            end
          end
        end
        ST_ADDRACK, ST_WDACK: begin
          if (sclFall) begin
            oeN    = 1'b0;
            stateN = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              bitCntN = '0;
              stateN  = ST_RACK;
            end else begin
              stb.shiftTx = 1'b1;
              bitCntN     = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) mAckN = ~sdaS;
          if (sclFall) begin
            if (mAck) begin
              stb.loadTx = 1'b1;
              stateN     = ST_RDATA;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      oe     <= 1'b0;
      rwBit  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= bitCntN;
      oe     <= oeN;
      rwBit  <= rwBitN;
      mAck   <= mAckN;
    end
  end

  assign sdaOe = oe | ((state == ST_RDATA) & ~txBit);

  // R10
  oe_hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));

  // R6
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> busy);

  // R6
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && busy) |=> state != ST_DEVACK);

endmodule

// File: rtl/eep_data.sv
module eep_data
  import eep_pkg::*;
#(
  parameter int MEM_DEPTH  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       pagePending
);

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0]      rxSh, txSh;
  logic [AW-1:0]   addr;
  logic [PAGE_BYTES-1:0] pageVld;
  logic [7:0]      mem     [MEM_DEPTH];
  logic [7:0]      pageBuf [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      txSh    <= '1;
      addr    <= '0;
      pageVld <= '0;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[6:0], stb.rxBit};
      if (stb.setAddr) addr <= rxSh[AW-1:0];
      if (stb.storeByte) begin
        pageVld[addr[PW-1:0]] <= 1'b1;
        addr[PW-1:0]          <= addr[PW-1:0] + 1'b1;
      end
      if (stb.loadTx) begin
        txSh <= mem[addr];
        addr <= addr + 1'b1;
      end else if (stb.shiftTx) begin
        txSh <= {txSh[6:0], 1'b1};
      end
      if (stb.commit || stb.dropPage) pageVld <= '0;
    end
  end

  // array and page buffer carry no reset
  always_ff @(posedge clk) begin
    if (stb.storeByte) pageBuf[addr[PW-1:0]] <= rxSh;
    if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageVld[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pageBuf[i];
      end
    end
  end

  assign rxByte      = rxSh;
  assign txBit       = txSh[7];
  assign pagePending = |pageVld;

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));

  // R7
  read_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> addr == $past(addr) + AW'(1));

  // R3
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !pagePending);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eep_pkg::*;
#(
  parameter int MEM_DEPTH   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int T_WRITE     = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrCtrl,
  output logic       sdaOe
);

  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic       txBit, pagePending;

  eep_ctrl #(
    .T_WRITE    (T_WRITE),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .chipSel    (chipSel),
    .wrCtrl     (wrCtrl),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .pagePending(pagePending),
    .stb        (stb),
    .sdaOe      (sdaOe)
  );

  eep_data #(
    .MEM_DEPTH (MEM_DEPTH),
    .PAGE_BYTES(PAGE_BYTES)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .pagePending(pagePending)
  );

  // R5
  guard_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pagePending) |-> !$past(wrCtrl));

endmodule

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int TW         = 300;
  localparam logic [7:0] DEVW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0, rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1, wrCtrl = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic sdaOe;
  wire  sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_i2c_target #(.T_WRITE(TW)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .chipSel(chipSel), .wrCtrl(wrCtrl), .sdaOe(sdaOe)
  );

  int    compared = 0, mismatched = 0;
  string curReq = "R1";
  bit    chkOn = 1'b0, expOe = 1'b0, done = 1'b0;
  int    modelMem[256];
  int    modelAddr = 0;
  int    wq[$];

  // per-clock comparison of the pull-down against the expected bus role
  always @(negedge clk) begin
    if (chkOn) begin
      compared++;
      if (sdaOe !== expOe) begin
        mismatched++;
        $display("FAIL %s/R10 sdaOe actual=%0b expected=%0b t=%0t", curReq, sdaOe, expOe, $time);
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmpVal(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sendBit(input bit b, input bit expDrv);
    sdaDrv = b;
    waitc(Q);
    sclDrv = 1'b1;
    expOe  = expDrv;
    chkOn  = 1'b1;
    waitc(2 * Q);
    chkOn  = 1'b0;
    sclDrv = 1'b0;
    waitc(Q);
  endtask

  task automatic readBit(output bit b);
    sdaDrv = 1'b1;
    waitc(Q);
    sclDrv = 1'b1;
    waitc(Q);
    b = sdaLine;
    waitc(Q);
    sclDrv = 1'b0;
    waitc(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit expAck);
    for (int i = 7; i >= 0; i--) sendBit(v[i], 1'b0);
    sendBit(1'b1, expAck);
  endtask

  task automatic readByte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(!ack, 1'b0);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclDrv = 1'b1;
    waitc(Q);
    sdaDrv = 1'b0;
    waitc(Q);
    sclDrv = 1'b0;
    waitc(Q);
  endtask

  task automatic busRestart();
    sdaDrv = 1'b1;
    waitc(Q);
    sclDrv = 1'b1;
    waitc(Q);
    sdaDrv = 1'b0;
    waitc(Q);
    sclDrv = 1'b0;
    waitc(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0;
    waitc(Q);
    sclDrv = 1'b1;
    waitc(Q);
    sdaDrv = 1'b1;
    waitc(2 * Q);
  endtask

  // write of the bytes in wq starting at address a
  task automatic doWrite(input int a, input bit waitDone);
    bit accept = !wrCtrl;
    busStart();
    sendByte(DEVW, 1'b1);
    sendByte(8'(a), 1'b1);
    foreach (wq[i]) sendByte(8'(wq[i]), accept);
    busStop();
    if (accept && wq.size() > 0) begin
      foreach (wq[i]) modelMem[(a & 'hF0) | ((a + i) & 'hF)] = wq[i];
      modelAddr = (a & 'hF0) | ((a + wq.size()) & 'hF);
      if (waitDone) waitc(TW + 100);
    end else begin
      modelAddr = a;
    end
  endtask

  task automatic readSeq(input int n);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      readByte(v, k < n - 1);
      if (modelMem[modelAddr] >= 0)
        cmpVal($sformatf("%s read@%0h", curReq, modelAddr), int'(v), modelMem[modelAddr]);
      modelAddr = (modelAddr + 1) & 'hFF;
    end
  endtask

  task automatic doRead(input int a, input int n);
    busStart();
    sendByte(DEVW, 1'b1);
    sendByte(8'(a), 1'b1);
    busRestart();
    sendByte(DEVR, 1'b1);
    modelAddr = a;
    readSeq(n);
    busStop();
  endtask

  task automatic curRead(input int n);
    busStart();
    sendByte(DEVR, 1'b1);
    readSeq(n);
    busStop();
  endtask

  initial begin
    foreach (modelMem[i]) modelMem[i] = -1;
    waitc(5);
    cmpVal("R1 oe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      waitc(1);
      cmpVal("R1 oe idle", int'(sdaOe), 0);
    end

    // R3 single byte write then random read
    curReq = "R3";
    wq = {8'h3C};
    doWrite('h12, 1'b1);
    doRead('h12, 1);

    // R4 page write crossing the page edge wraps to 0x20
    curReq = "R4";
    wq = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    doWrite('h2E, 1'b1);
    doRead('h20, 16);

    // R7 sequential read across top of array; R8 current address
    curReq = "R7";
    wq = {8'hA5}; doWrite('hFF, 1'b1);
    wq = {8'h5A}; doWrite('h00, 1'b1);
    wq = {8'h77}; doWrite('h01, 1'b1);
    doRead('hFF, 2);
    curReq = "R8";
    curRead(1);

    // R2 wrong pin bits, then wrong upper nibble; following bytes ignored
    curReq = "R2";
    busStart();
    sendByte(8'hA0, 1'b0);
    sendByte(8'h12, 1'b0);
    sendByte(8'h00, 1'b0);
    busStop();
    busStart();
    sendByte(8'hBA, 1'b0);
    busStop();
    doRead('h12, 1);

    // R5 guard high: data refused, array intact, no busy period
    curReq = "R5";
    wrCtrl = 1'b1;
    wq = {8'h99, 8'h98};
    doWrite('h12, 1'b0);
    wrCtrl = 1'b0;
    doRead('h12, 1);

    // R6 polling during the write cycle
    curReq = "R6";
    wq = {8'h11};
    doWrite('h40, 1'b0);
    busStart();
    sendByte(DEVW, 1'b0);
    busStop();
    waitc(TW + 100);
    busStart();
    sendByte(DEVW, 1'b1);
    busStop();
    doRead('h40, 1);

    // R9 write cut by repeated START is discarded
    curReq = "R9";
    wq = {8'h44};
    doWrite('h50, 1'b1);
    busStart();
    sendByte(DEVW, 1'b1);
    sendByte(8'h50, 1'b1);
    sendByte(8'h66, 1'b1);
    busRestart();
    sendByte(DEVW, 1'b1);
    busStop();
    doRead('h50, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule